// File: doc/BRIEF.md
# Modular Add-Compare-Select Butterfly

This block performs one radix-2 add-compare-select step of a 64-state Viterbi trellis. Each enabled clock it takes the metrics of an upper and a lower predecessor state and four ready-made branch metrics. The branch metrics are the sum, the difference, and the negations of both, formed from two signed soft inputs. It returns the new path metrics of its two successor states, plus one survivor decision bit for each successor. Thirty-two copies, wired to the trellis, make a full state update.

Path metrics are never renormalised. They are kept modulo 512 in 9 bits and allowed to wrap. The compare therefore reads the sign bit of a 9-bit difference, which gives the right answer as long as live metrics lie within 255 of each other. The trellis keeps them within 176.

Both the branch-metric adders and the compare subtractors are carry-select adders. In each section, the carry-in-one result is made from the carry-in-zero result by a gate-level increment rather than by a second adder. Registers update only while the enable is high. A one-cycle delayed copy of the enable is passed downstream to the decision buffer.

Top module: `acs_butterfly_modular`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, pm_s0, pm_s1, dec_s0, dec_s1 and fifo_enable are all 0.
- R2: The two ports bm_pos and bm_neg are chosen by bfly_kind: 0 gives (bm_sum, bm_nsum), 1 gives (bm_nsum, bm_sum), 2 gives (bm_diff, bm_ndiff) and 3 gives (bm_ndiff, bm_diff). Each branch metric is a 5-bit two's-complement value, sign-extended to 9 bits before it is added.
- R3: One cycle after an enabled edge, pm_s0 holds the modular minimum of (pm_up_in + bm_pos) and (pm_lo_in + bm_neg), taken mod 512.
- R4: One cycle after an enabled edge, pm_s1 holds the modular minimum of (pm_up_in + bm_neg) and (pm_lo_in + bm_pos), taken mod 512.
- R5: Each decision bit is 1 when the lower predecessor's candidate is strictly smaller, and 0 when the upper predecessor's candidate is kept.
- R6: When the two candidates are equal, the upper predecessor wins and the decision bit is 0.
- R7: The compare is correct when metrics wrap through 511 to 0, provided the true candidate values differ by less than 256.
- R8: All additions are 9-bit carry-select sums: 5+4 sections for the adders and 2+3+4 sections for the subtractors. Each upper section is selected between a sum and that sum incremented. The results equal the plain sum mod 512.
- R9: While acs_enable is low at a clock edge, pm_s0, pm_s1, dec_s0 and dec_s1 keep their values.
- R10: fifo_enable equals acs_enable as it was sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acs_enable | input | 1 | Update enable for the butterfly registers |
| bfly_kind | input | 2 | Selects which branch metrics feed the two branches |
| pm_up_in | input | 9 | Path metric of the upper predecessor |
| pm_lo_in | input | 9 | Path metric of the lower predecessor |
| bm_sum | input | 5 | Sum of the soft inputs |
| bm_diff | input | 5 | Difference of the soft inputs |
| bm_nsum | input | 5 | Negated sum |
| bm_ndiff | input | 5 | Negated difference |
| pm_s0 | output | 9 | New metric of successor 0 |
| pm_s1 | output | 9 | New metric of successor 1 |
| dec_s0 | output | 1 | Survivor decision for successor 0 |
| dec_s1 | output | 1 | Survivor decision for successor 1 |
| fifo_enable | output | 1 | acs_enable delayed by one cycle |

## Verification
Two effects can fall in the same cycle: a metric wrapping through the top of the modulus, and a tie between candidates. When both happen, the sign bit and the tie rule have to agree. Vectors are built from unbounded integer metrics. Some place one predecessor just below 512 and the other just above it, and others give the two candidates equal values. Each result is judged against the integer minimum reduced mod 512, and against the decision bit the reference chose with ties going to the upper predecessor.

// File: rtl/acs_butterfly_modular.sv
module acs_butterfly_modular #(
  parameter int PM_W   = 9,
  parameter int BM_W   = 5,
  parameter int SUB_S1 = 2,
  parameter int SUB_S2 = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acs_enable,
  input  logic [1:0]      bfly_kind,
  input  logic [PM_W-1:0] pm_up_in,
  input  logic [PM_W-1:0] pm_lo_in,
  input  logic [BM_W-1:0] bm_sum,
  input  logic [BM_W-1:0] bm_diff,
  input  logic [BM_W-1:0] bm_nsum,
  input  logic [BM_W-1:0] bm_ndiff,
  output logic [PM_W-1:0] pm_s0,
  output logic [PM_W-1:0] pm_s1,
  output logic            dec_s0,
  output logic            dec_s1,
  output logic            fifo_enable
);

  localparam logic [PM_W-1:0] ADD_STARTS = PM_W'(1) << BM_W;
  localparam logic [PM_W-1:0] SUB_STARTS = (PM_W'(1) << SUB_S1) | (PM_W'(1) << SUB_S2);

  // Carry-select sum: each section ripples with carry-in 0, and the
  // carry-in-1 result is that sum incremented (bit flips where all lower bits are 1).
  function automatic logic [PM_W:0] cs_add(input logic [PM_W-1:0] a,
                                           input logic [PM_W-1:0] b,
                                           input logic            cin,
                                           input logic [PM_W-1:0] starts);
    logic [PM_W-1:0] res;
    logic csel, cz, all1, s0, sec_cout;
    csel = cin; cz = 1'b0; all1 = 1'b1; sec_cout = 1'b0;
    for (int i = 0; i < PM_W; i++) begin
      if (starts[i] && i != 0) begin
        csel = sec_cout; cz = 1'b0; all1 = 1'b1;
      end
      s0       = a[i] ^ b[i] ^ cz;
      cz       = (a[i] & b[i]) | (a[i] & cz) | (b[i] & cz);
      res[i]   = csel ? (s0 ^ all1) : s0;
      all1     = all1 & s0;
      sec_cout = csel ? (cz | all1) : cz;
    end
    return {sec_cout, res};
  endfunction

  logic [BM_W-1:0] bm_pos, bm_neg;
  always_comb begin
    unique case (bfly_kind)
      2'd0: begin bm_pos = bm_sum;   bm_neg = bm_nsum;  end
      2'd1: begin bm_pos = bm_nsum;  bm_neg = bm_sum;   end
      2'd2: begin bm_pos = bm_diff;  bm_neg = bm_ndiff; end
      default: begin bm_pos = bm_ndiff; bm_neg = bm_diff; end
    endcase
  end

  logic [PM_W-1:0] bx_pos, bx_neg;
  assign bx_pos = {{(PM_W-BM_W){bm_pos[BM_W-1]}}, bm_pos};
  assign bx_neg = {{(PM_W-BM_W){bm_neg[BM_W-1]}}, bm_neg};

  logic [PM_W:0] sum_u0, sum_l0, sum_u1, sum_l1, dif0, dif1;
  logic [PM_W-1:0] cu0, cl0, cu1, cl1;
  assign sum_u0 = cs_add(pm_up_in, bx_pos, 1'b0, ADD_STARTS);
  assign sum_l0 = cs_add(pm_lo_in, bx_neg, 1'b0, ADD_STARTS);
  assign sum_u1 = cs_add(pm_up_in, bx_neg, 1'b0, ADD_STARTS);
  assign sum_l1 = cs_add(pm_lo_in, bx_pos, 1'b0, ADD_STARTS);
  assign cu0 = sum_u0[PM_W-1:0];
  assign cl0 = sum_l0[PM_W-1:0];
  assign cu1 = sum_u1[PM_W-1:0];
  assign cl1 = sum_l1[PM_W-1:0];

  assign dif0 = cs_add(cl0, ~cu0, 1'b1, SUB_STARTS);
  assign dif1 = cs_add(cl1, ~cu1, 1'b1, SUB_STARTS);

  logic pick0, pick1;
  assign pick0 = dif0[PM_W-1];
  assign pick1 = dif1[PM_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_s0 <= '0; pm_s1 <= '0; dec_s0 <= 1'b0; dec_s1 <= 1'b0; fifo_enable <= 1'b0;
    end else begin
      fifo_enable <= acs_enable;
      if (acs_enable) begin
        pm_s0  <= pick0 ? cl0 : cu0;
        pm_s1  <= pick1 ? cl1 : cu1;
        dec_s0 <= pick0;
        dec_s1 <= pick1;
      end
    end
  end

  // R8
  adder_mod_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cu0 == PM_W'(pm_up_in + bx_pos) && cl1 == PM_W'(pm_lo_in + bx_pos));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acs_enable |=> $stable(pm_s0) && $stable(pm_s1) && $stable(dec_s0) && $stable(dec_s1));

  // R10
  fifo_enable_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fifo_enable == $past(acs_enable));

  // R3
  s0_not_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acs_enable |=> !(PM_W'(pm_s0 - $past(cu0)) != '0 && !(PM_W'(pm_s0 - $past(cu0)) >> (PM_W-1)))
                && !(PM_W'(pm_s0 - $past(cl0)) != '0 && !(PM_W'(pm_s0 - $past(cl0)) >> (PM_W-1))));

  // R6
  tie_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acs_enable && cu1 == cl1 |=> !dec_s1);

endmodule

// File: tb/acs_butterfly_modular_tb.sv
module acs_butterfly_modular_tb;
  logic clk = 1'b0, rst_n = 1'b0, acs_enable = 1'b0;
  logic [1:0] bfly_kind = 2'd0;
  logic [8:0] pm_up_in = '0, pm_lo_in = '0;
  logic [4:0] bm_sum = '0, bm_diff = '0, bm_nsum = '0, bm_ndiff = '0;
  logic [8:0] pm_s0, pm_s1;
  logic dec_s0, dec_s1, fifo_enable;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acs_butterfly_modular u_dut (.*);

  // columns: upper metric, lower metric, soft a, soft b, kind (soft in -7..7)
  localparam int NV = 14;
  localparam int VEC [NV][5] = '{
    '{100, 100, 0, 0, 0}, '{200, 150, 3, 2, 0}, '{500, 520, -7, 7, 1},
    '{511, 512, 7, 7, 0}, '{1000, 1176, -7, -7, 2}, '{1176, 1000, 7, -1, 3},
    '{300, 290, 5, -5, 0}, '{505, 400, -3, 6, 1}, '{40, 60, -7, -6, 2},
    '{255, 256, 4, 4, 3}, '{620, 510, 1, -2, 0}, '{-20, 10, 6, -3, 1},
    '{510, 514, 1, -1, 0}, '{700, 650, -2, 5, 2}};

  function automatic int md(input int x); return ((x % 512) + 512) % 512; endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int u, input int l, input int a, input int b, input int k);
    int s, d, pos, neg, cu0, cl0, cu1, cl1, e0, e1;
    bit d0, d1;
    s = a + b; d = a - b;
    @(negedge clk);
    bm_sum = 5'(s); bm_nsum = 5'(-s); bm_diff = 5'(d); bm_ndiff = 5'(-d);
    pm_up_in = 9'(md(u)); pm_lo_in = 9'(md(l)); bfly_kind = 2'(k); acs_enable = 1'b1;
    pos = (k == 0) ? s : (k == 1) ? -s : (k == 2) ? d : -d;
    neg = -pos;
    cu0 = u + pos; cl0 = l + neg; cu1 = u + neg; cl1 = l + pos;
    d0 = cl0 < cu0; d1 = cl1 < cu1;
    e0 = d0 ? cl0 : cu0; e1 = d1 ? cl1 : cu1;
    @(posedge clk); #1;
    check("R3/R7 pm_s0", pm_s0, md(e0));
    check("R4/R7 pm_s1", pm_s1, md(e1));
    check((cu0 == cl0) ? "R6 dec_s0 tie" : "R5 dec_s0", dec_s0, d0);
    check((cu1 == cl1) ? "R6 dec_s1 tie" : "R5 dec_s1", dec_s1, d1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [8:0] h0, h1;
    logic hd0, hd1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pm_s0", pm_s0, 0);
    check("R1 reset pm_s1", pm_s1, 0);
    check("R1 reset decisions", {dec_s0, dec_s1}, 0);
    check("R1 reset fifo_enable", fifo_enable, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 first cycle out of reset", {pm_s0, dec_s0, fifo_enable}, 0);

    for (int i = 0; i < NV; i++) apply(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
    // R2 R8: every kind across a wrap boundary
    for (int k = 0; k < 4; k++) apply(505, 515, 6, -4, k);
    check("R10 fifo_enable after enabled cycle", fifo_enable, 1);

    // R9: disabled edge with changed inputs must leave outputs alone
    h0 = pm_s0; h1 = pm_s1; hd0 = dec_s0; hd1 = dec_s1;
    @(negedge clk);
    acs_enable = 1'b0; pm_up_in = 9'd7; pm_lo_in = 9'd300; bm_sum = 5'd9; bm_nsum = -5'sd9;
    @(posedge clk); #1;
    check("R10 fifo_enable follows low enable", fifo_enable, 0);
    @(posedge clk); #1;
    check("R9 hold pm_s0", pm_s0, h0);
    check("R9 hold pm_s1", pm_s1, h1);
    check("R9 hold decisions", {dec_s0, dec_s1}, {hd0, hd1});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule